// File: doc/BRIEF.md
# Slot and Sample Timing Counters

This block keeps the time-division timing of a radio baseband. It has two cascaded counters. A sample counter advances on each sample tick and wraps at a programmable number of samples per slot. A slot counter advances each time the sample counter wraps, and it wraps at a programmable number of slots per minute.

There are two timing modes. In sync mode a one-pulse-per-second reference, taken through a two-flop synchroniser, realigns the sample phase. In free-run mode the reference is ignored, and the host keeps alignment by writing signed sample corrections. A correction takes effect at the next slot boundary.

The block also serves the modem around it in two ways. When a received message starts, it captures the slot and sample values and holds them until the host reads them. When the counters reach a host-programmed slot and sample, it raises a one-cycle transmit start strobe, but only if the schedule is armed.

Top module: `slot_timer`

## Requirements
- R1: On every clock with `tick` high, the sample counter increments by one. After the value `cfg_sps`-1 it returns to 0. `cfg_sps` must be at least 2.
- R2: The slot counter increments on each tick where the sample counter wraps. After `cfg_slots`-1 it returns to 0. A `cfg_slots` value of 0 selects 2250 slots.
- R3: While `tick` is low, both counters hold their values.
- R4: With `sync_en`=1, a rising edge on `pps_in` that is first sampled at clock edge k loads `cfg_pps_phase` into the sample counter. This happens on the first tick at or after edge k+2. If no tick occurs in that cycle, the load waits for the next tick. The slot counter is not reset by the pulse.
- R5: With `sync_en`=0, `pps_in` has no effect, and the counters keep stepping as in R1 and R2.
- R6: With `sync_en`=0, a pulse on `adj_wr` stores the signed value a from `adj_val`, where |a| < `cfg_sps`. At the next wrap tick the sample counter loads a when a ≥ 0, or `cfg_sps`+a when a < 0, in place of 0. The slot counter still advances, and ticks before that wrap are not affected.
- R7: With `sync_en`=1, `adj_wr` is ignored, and a wrap loads 0.
- R8: A pulse on `rx_start` while no capture is unread has two effects in the next cycle. `cap_slot` and `cap_sample` equal the counter values present during the `rx_start` cycle, and `cap_valid` is 1.
- R9: A pulse on `rx_start` while `cap_valid`=1 and `cap_rd`=0 leaves the capture unchanged and sets the sticky `cap_overrun` flag. A pulse on `cap_rd` clears `cap_valid` and `cap_overrun` in the next cycle.
- R10: A pulse on `tx_wr` stores `tx_slot` and `tx_sample` and sets `tx_armed` in the next cycle. Take a tick during which the counters equal the stored target while the schedule is armed. In the cycle after that tick, `tx_start` is high for exactly one cycle and `tx_armed` drops to 0.
- R11: While `tx_armed`=0, `tx_start` stays low, even when the counters pass the stored target.
- R12: During reset, all counters, the capture outputs, `tx_armed` and `tx_start` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Sample tick enable, one clock wide per sample |
| pps_in | input | 1 | Asynchronous one-pulse-per-second reference |
| sync_en | input | 1 | 1 = sync mode, 0 = free-run mode |
| cfg_sps | input | SAMPLE_W | Samples per slot |
| cfg_slots | input | SLOT_W | Slots per minute (0 selects 2250) |
| cfg_pps_phase | input | SAMPLE_W | Sample value loaded on a reference pulse |
| adj_wr | input | 1 | Correction write strobe |
| adj_val | input | SAMPLE_W | Signed sample correction |
| rx_start | input | 1 | Start of a received message |
| cap_rd | input | 1 | Host read of the capture registers |
| tx_wr | input | 1 | Transmit schedule write and arm |
| tx_slot | input | SLOT_W | Scheduled transmit slot |
| tx_sample | input | SAMPLE_W | Scheduled transmit sample |
| cur_sample | output | SAMPLE_W | Current sample count |
| cur_slot | output | SLOT_W | Current slot count |
| cap_sample | output | SAMPLE_W | Captured sample count |
| cap_slot | output | SLOT_W | Captured slot count |
| cap_valid | output | 1 | An unread capture is held |
| cap_overrun | output | 1 | Sticky: a capture was lost |
| tx_armed | output | 1 | Transmit schedule pending |
| tx_start | output | 1 | One-cycle transmit start strobe |

## Verification
A wrong counter state shows up on `cur_sample` and `cur_slot` in the cycle after the offending tick. A wrong wrap or slot terminal value becomes visible at the latest one full minute cycle later. A lost reference pulse, or a correction that is pending but not applied, appears as a wrong sample value right after the next tick or the next wrap. A bad capture shows on the capture outputs one cycle after `rx_start`. A fault in the transmit schedule appears as a missing, doubled or misplaced `tx_start` no later than one cycle after the target tick, or as a stray strobe within one minute cycle after disarm.

// File: rtl/slot_timer_pkg.sv
// Package: shared constants and mode encoding for the slot timer.
// Assumes: included first in compile order.
package slot_timer_pkg;
    localparam int unsigned DEF_SLOTS = 2250;

    typedef enum logic {
        MODE_FREE = 1'b0,
        MODE_SYNC = 1'b1
    } sync_mode_e;
endpackage

// File: rtl/st_pps_sync.sv
// Module: brings the asynchronous reference pulse into the clock domain and
// emits a one-cycle pulse on its rising edge.
// Assumes: the pulse stays high for at least two clock cycles.
module st_pps_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pps_in,
    output logic pps_rise
);
    logic [STAGES:0] chain;

    // Shift the reference through the synchroniser and one edge stage.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], pps_in};
    end

    assign pps_rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/st_counters.sv
// Module: cascaded sample-in-slot and slot-in-minute counters. In sync mode
// they are realigned by the reference; in free-run mode they are trimmed by
// host corrections.
// Assumes: sps >= 2, phase < sps, |adjust| < sps, configuration is changed
// only while in reset.
module st_counters
    import slot_timer_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int SLOT_W   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                sync_en,
    input  logic                pps_rise,
    input  logic [SAMPLE_W-1:0] sps,
    input  logic [SLOT_W-1:0]   slots,
    input  logic [SAMPLE_W-1:0] phase,
    input  logic                adj_wr,
    input  logic [SAMPLE_W-1:0] adj_val,
    output logic [SAMPLE_W-1:0] sample,
    output logic [SLOT_W-1:0]   slot
);
    localparam logic [SLOT_W-1:0] SLOTS_DEF = SLOT_W'(DEF_SLOTS);

    logic [SLOT_W-1:0]   slots_eff;
    logic [SLOT_W-1:0]   slots_m1;
    logic [SAMPLE_W-1:0] sps_m1;
    logic                wrap;
    logic                pps_pend;
    logic                load_phase;
    logic                adj_pend;
    logic [SAMPLE_W-1:0] adj_q;
    logic [SAMPLE_W-1:0] adj_tgt;
    sync_mode_e          mode;

    assign mode       = sync_mode_e'(sync_en);
    assign slots_eff  = (slots == '0) ? SLOTS_DEF : slots;
    assign slots_m1   = slots_eff - 1'b1;
    assign sps_m1     = sps - 1'b1;
    assign wrap       = (sample == sps_m1);
    assign load_phase = (mode == MODE_SYNC) && (pps_pend || pps_rise);
    assign adj_tgt    = adj_q[SAMPLE_W-1] ? (sps + adj_q) : adj_q;

    // Hold a reference edge until a tick can apply it.
    always_ff @(posedge clk) begin
        if (!rst_n)                 pps_pend <= 1'b0;
        else if (mode != MODE_SYNC) pps_pend <= 1'b0;
        else if (tick)              pps_pend <= 1'b0;
        else if (pps_rise)          pps_pend <= 1'b1;
    end

    // Hold a host correction until the next slot boundary (free-run only).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adj_pend <= 1'b0;
            adj_q    <= '0;
        end else if (mode == MODE_SYNC) begin
            adj_pend <= 1'b0;
        end else if (adj_wr) begin
            adj_pend <= 1'b1;
            adj_q    <= adj_val;
        end else if (tick && wrap) begin
            adj_pend <= 1'b0;
        end
    end

    // Step the sample counter; the reference load has priority over a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample <= '0;
        end else if (tick) begin
            if (load_phase)    sample <= phase;
            else if (wrap)     sample <= adj_pend ? adj_tgt : '0;
            else               sample <= sample + 1'b1;
        end
    end

    // Step the slot counter on each sample wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)            slot <= '0;
        else if (tick && wrap) slot <= (slot == slots_m1) ? '0 : slot + 1'b1;
    end

    // R1: in free-run, a non-wrap tick advances the sample by one.
    p_free_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !sync_en && sample != sps_m1) |=> sample == $past(sample) + 1'b1);

    // R1: the sample stays inside the slot.
    p_sample_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sample < sps);

    // R2: the slot stays inside the minute.
    p_slot_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        slot < slots_eff);

    // R3: without a tick nothing moves.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(sample) && $stable(slot)));

    // R4: a synchronised edge met by a tick loads the phase.
    p_pps_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sync_en && pps_rise) |=> sample == $past(phase));
endmodule

// File: rtl/st_capture.sv
// Module: latches the slot/sample time of a received message start and
// holds it until the host reads it; flags lost captures.
// Assumes: rx_start and cap_rd are one-cycle strobes.
module st_capture #(
    parameter int SAMPLE_W = 16,
    parameter int SLOT_W   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_start,
    input  logic                cap_rd,
    input  logic [SAMPLE_W-1:0] cur_sample,
    input  logic [SLOT_W-1:0]   cur_slot,
    output logic [SAMPLE_W-1:0] cap_sample,
    output logic [SLOT_W-1:0]   cap_slot,
    output logic                cap_valid,
    output logic                cap_overrun
);
    logic take;

    assign take = rx_start && (!cap_valid || cap_rd);

    // Latch the timestamp when the holding registers are free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_sample <= '0;
            cap_slot   <= '0;
        end else if (take) begin
            cap_sample <= cur_sample;
            cap_slot   <= cur_slot;
        end
    end

    // Track whether an unread capture is held.
    always_ff @(posedge clk) begin
        if (!rst_n)      cap_valid <= 1'b0;
        else if (take)   cap_valid <= 1'b1;
        else if (cap_rd) cap_valid <= 1'b0;
    end

    // Sticky loss flag, cleared by a host read.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cap_overrun <= 1'b0;
        else if (cap_rd)                 cap_overrun <= 1'b0;
        else if (rx_start && cap_valid)  cap_overrun <= 1'b1;
    end

    // R9: an unread capture does not change.
    p_cap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && !cap_rd) |=> ($stable(cap_sample) && $stable(cap_slot) && cap_valid));

    // R9: a capture arriving on a full holder sets the loss flag.
    p_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && rx_start && !cap_rd) |=> cap_overrun);
endmodule

// File: rtl/st_tx_sched.sv
// Module: holds one scheduled transmit time and issues a one-cycle start
// strobe on the tick where the counters reach it.
// Assumes: a new write replaces any pending schedule.
module st_tx_sched #(
    parameter int SAMPLE_W = 16,
    parameter int SLOT_W   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [SAMPLE_W-1:0] cur_sample,
    input  logic [SLOT_W-1:0]   cur_slot,
    input  logic                tx_wr,
    input  logic [SLOT_W-1:0]   tx_slot,
    input  logic [SAMPLE_W-1:0] tx_sample,
    output logic                tx_armed,
    output logic                tx_start
);
    logic [SLOT_W-1:0]   tgt_slot;
    logic [SAMPLE_W-1:0] tgt_sample;
    logic                hit;

    assign hit = (cur_slot == tgt_slot) && (cur_sample == tgt_sample);

    // Store the target, arm, and fire once on the matching tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_slot   <= '0;
            tgt_sample <= '0;
            tx_armed   <= 1'b0;
            tx_start   <= 1'b0;
        end else begin
            tx_start <= 1'b0;
            if (tx_wr) begin
                tgt_slot   <= tx_slot;
                tgt_sample <= tx_sample;
                tx_armed   <= 1'b1;
            end else if (tx_armed && tick && hit) begin
                tx_start <= 1'b1;
                tx_armed <= 1'b0;
            end
        end
    end

    // R10: the strobe lasts a single cycle.
    p_tx_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);

    // R11: a strobe only follows an armed schedule, and disarms it.
    p_tx_armed_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> ($past(tx_armed) && !tx_armed));
endmodule

// File: rtl/slot_timer.sv
// Module: top of the slot/sample timing block. It connects the reference
// synchroniser, the counters, the receive capture and the transmit scheduler.
// Assumes: all host inputs are synchronous strobes or static configuration.
module slot_timer #(
    parameter int SAMPLE_W    = 16,
    parameter int SLOT_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                pps_in,
    input  logic                sync_en,
    input  logic [SAMPLE_W-1:0] cfg_sps,
    input  logic [SLOT_W-1:0]   cfg_slots,
    input  logic [SAMPLE_W-1:0] cfg_pps_phase,
    input  logic                adj_wr,
    input  logic [SAMPLE_W-1:0] adj_val,
    input  logic                rx_start,
    input  logic                cap_rd,
    input  logic                tx_wr,
    input  logic [SLOT_W-1:0]   tx_slot,
    input  logic [SAMPLE_W-1:0] tx_sample,
    output logic [SAMPLE_W-1:0] cur_sample,
    output logic [SLOT_W-1:0]   cur_slot,
    output logic [SAMPLE_W-1:0] cap_sample,
    output logic [SLOT_W-1:0]   cap_slot,
    output logic                cap_valid,
    output logic                cap_overrun,
    output logic                tx_armed,
    output logic                tx_start
);
    logic pps_rise;

    st_pps_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pps_in(pps_in), .pps_rise(pps_rise)
    );

    st_counters #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sync_en(sync_en),
        .pps_rise(pps_rise), .sps(cfg_sps), .slots(cfg_slots),
        .phase(cfg_pps_phase), .adj_wr(adj_wr), .adj_val(adj_val),
        .sample(cur_sample), .slot(cur_slot)
    );

    st_capture #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .cap_rd(cap_rd),
        .cur_sample(cur_sample), .cur_slot(cur_slot),
        .cap_sample(cap_sample), .cap_slot(cap_slot),
        .cap_valid(cap_valid), .cap_overrun(cap_overrun)
    );

    st_tx_sched #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cur_sample(cur_sample), .cur_slot(cur_slot),
        .tx_wr(tx_wr), .tx_slot(tx_slot), .tx_sample(tx_sample),
        .tx_armed(tx_armed), .tx_start(tx_start)
    );

    // R12: the outputs are zero in the first cycle after reset.
    p_reset_r12: assert property (@(posedge clk)
        !rst_n |=> (cur_sample == '0 && cur_slot == '0 && !cap_valid && !tx_armed && !tx_start));
endmodule

// File: tb/slot_timer_tb.sv
`timescale 1ns/1ps
module slot_timer_tb;
    localparam int SW = 16;
    localparam int LW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1, pps_in = 1'b0, sync_en = 1'b0;
    logic [SW-1:0] cfg_sps = 16'd8, cfg_pps_phase = 16'd5, adj_val = '0, tx_sample = '0;
    logic [LW-1:0] cfg_slots = 12'd5, tx_slot = '0;
    logic adj_wr = 1'b0, rx_start = 1'b0, cap_rd = 1'b0, tx_wr = 1'b0;
    logic [SW-1:0] cur_sample, cap_sample;
    logic [LW-1:0] cur_slot, cap_slot;
    logic cap_valid, cap_overrun, tx_armed, tx_start;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // Bench model of the counters
    int m_sample = 0, m_slot = 0, m_sps = 8, m_slots = 5;
    int p_sample = 0, p_slot = 0;
    bit m_load = 0;
    bit m_adj = 0;
    int m_adj_tgt = 0;

    always #2.5 clk = ~clk;

    slot_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pps_in(pps_in), .sync_en(sync_en),
        .cfg_sps(cfg_sps), .cfg_slots(cfg_slots), .cfg_pps_phase(cfg_pps_phase),
        .adj_wr(adj_wr), .adj_val(adj_val), .rx_start(rx_start), .cap_rd(cap_rd),
        .tx_wr(tx_wr), .tx_slot(tx_slot), .tx_sample(tx_sample),
        .cur_sample(cur_sample), .cur_slot(cur_slot), .cap_sample(cap_sample),
        .cap_slot(cap_slot), .cap_valid(cap_valid), .cap_overrun(cap_overrun),
        .tx_armed(tx_armed), .tx_start(tx_start)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // One clock: model the edge with the inputs driven, then wait for negedge.
    task automatic cyc();
        @(posedge clk);
        p_sample = m_sample;
        p_slot   = m_slot;
        if (tick) begin
            bit w;
            w = (m_sample == m_sps - 1);
            if (w) m_slot = (m_slot == m_slots - 1) ? 0 : m_slot + 1;
            if (m_load)      m_sample = int'(cfg_pps_phase);
            else if (w)      m_sample = m_adj ? m_adj_tgt : 0;
            else             m_sample = m_sample + 1;
            m_load = 0;
            if (w) m_adj = 0;
        end
        @(negedge clk);
    endtask

    task automatic chk_cnt(input string tag);
        chk({tag, " sample"}, int'(cur_sample), m_sample);
        chk({tag, " slot"}, int'(cur_slot), m_slot);
    endtask

    task automatic do_reset(input int sps, input int slots, input int mslots);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_sps = SW'(sps);
        cfg_slots = LW'(slots);
        m_sps = sps; m_slots = mslots;
        m_sample = 0; m_slot = 0; m_load = 0; m_adj = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R12 sample", int'(cur_sample), 0);
        chk("R12 slot", int'(cur_slot), 0);
        chk("R12 valid", int'(cap_valid), 0);
        chk("R12 armed", int'(tx_armed), 0);
        chk("R12 start", int'(tx_start), 0);
    endtask

    task automatic t_count();
        for (int i = 0; i < 45; i++) begin
            cyc();
            chk_cnt("R1 R2 count");
        end
    endtask

    task automatic t_hold();
        tick = 1'b0;
        for (int i = 0; i < 6; i++) begin
            cyc();
            chk_cnt("R3 hold");
        end
        tick = 1'b1;
    endtask

    task automatic t_default_slots();
        do_reset(4, 0, 2250);
        for (int i = 0; i < 2250 * 4 - 1; i++) cyc();
        chk("R2 default last slot", int'(cur_slot), 2249);
        chk("R2 default last sample", int'(cur_sample), 3);
        cyc();
        chk_cnt("R2 default wrap");
        chk("R2 default wrap zero", int'(cur_slot), 0);
    endtask

    task automatic t_pps();
        do_reset(8, 5, 5);
        sync_en = 1'b1;
        cyc(); cyc();
        pps_in = 1'b1;
        cyc(); cyc();
        pps_in = 1'b0;
        m_load = 1;
        cyc();
        chk("R4 phase load", int'(cur_sample), 5);
        chk_cnt("R4 after load");
        for (int i = 0; i < 10; i++) begin
            cyc();
            chk_cnt("R4 run");
        end
        // Pulse while ticks are stopped: the load waits for a tick.
        tick = 1'b0;
        pps_in = 1'b1;
        repeat (3) cyc();
        pps_in = 1'b0;
        repeat (3) cyc();
        chk_cnt("R4 pending hold");
        tick = 1'b1;
        m_load = 1;
        cyc();
        chk("R4 pending load", int'(cur_sample), 5);
        chk_cnt("R4 pending");
    endtask

    task automatic t_pps_free();
        sync_en = 1'b0;
        repeat (3) cyc();
        pps_in = 1'b1;
        repeat (3) cyc();
        pps_in = 1'b0;
        for (int i = 0; i < 8; i++) begin
            cyc();
            chk_cnt("R5 free ignores pps");
        end
    endtask

    task automatic t_adjust();
        do_reset(8, 5, 5);
        sync_en = 1'b0;
        repeat (3) cyc();
        adj_val = SW'(2);
        adj_wr = 1'b1;
        cyc();
        adj_wr = 1'b0;
        m_adj = 1; m_adj_tgt = 2;
        for (int i = 0; i < 12; i++) begin
            cyc();
            chk_cnt("R6 positive adjust");
        end
        adj_val = -SW'(3);
        adj_wr = 1'b1;
        cyc();
        adj_wr = 1'b0;
        m_adj = 1; m_adj_tgt = 5;
        for (int i = 0; i < 12; i++) begin
            cyc();
            chk_cnt("R6 negative adjust");
        end
        sync_en = 1'b1;
        adj_val = SW'(4);
        adj_wr = 1'b1;
        cyc();
        adj_wr = 1'b0;
        for (int i = 0; i < 12; i++) begin
            cyc();
            chk_cnt("R7 sync ignores adjust");
        end
        sync_en = 1'b0;
    endtask

    task automatic t_capture();
        int es, el;
        cyc();
        es = m_sample; el = m_slot;
        rx_start = 1'b1;
        cyc();
        rx_start = 1'b0;
        chk("R8 cap sample", int'(cap_sample), es);
        chk("R8 cap slot", int'(cap_slot), el);
        chk("R8 cap valid", int'(cap_valid), 1);
        chk("R8 no overrun", int'(cap_overrun), 0);
        repeat (3) cyc();
        rx_start = 1'b1;
        cyc();
        rx_start = 1'b0;
        chk("R9 held sample", int'(cap_sample), es);
        chk("R9 held slot", int'(cap_slot), el);
        chk("R9 overrun", int'(cap_overrun), 1);
        cyc();
        chk("R9 overrun sticky", int'(cap_overrun), 1);
        cap_rd = 1'b1;
        cyc();
        cap_rd = 1'b0;
        chk("R9 read clears valid", int'(cap_valid), 0);
        chk("R9 read clears overrun", int'(cap_overrun), 0);
        repeat (2) cyc();
        es = m_sample; el = m_slot;
        rx_start = 1'b1;
        cyc();
        rx_start = 1'b0;
        chk("R8 fresh sample", int'(cap_sample), es);
        chk("R8 fresh slot", int'(cap_slot), el);
    endtask

    task automatic t_tx();
        int ts, tl, pulses, bad_pos;
        ts = 3;
        tl = (m_slot + 2) % m_slots;
        tx_slot = LW'(tl);
        tx_sample = SW'(ts);
        tx_wr = 1'b1;
        cyc();
        tx_wr = 1'b0;
        chk("R10 armed", int'(tx_armed), 1);
        pulses = 0; bad_pos = 0;
        for (int i = 0; i < 60; i++) begin
            cyc();
            if (tx_start) begin
                pulses++;
                if (!(p_sample == ts && p_slot == tl)) bad_pos++;
            end
        end
        chk("R10 pulse count", pulses, 1);
        chk("R10 pulse position", bad_pos, 0);
        chk("R10 disarmed", int'(tx_armed), 0);
        pulses = 0;
        for (int i = 0; i < 50; i++) begin
            cyc();
            if (tx_start) pulses++;
        end
        chk("R11 no strobe unarmed", pulses, 0);
    endtask

    initial begin
        do_reset(8, 5, 5);
        rst_n = 1'b0;
        t_reset();
        rst_n = 1'b1;
        t_count();
        t_hold();
        t_default_slots();
        t_pps();
        t_pps_free();
        t_adjust();
        t_capture();
        t_tx();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule